// File: doc/BRIEF.md
# Interrupt Recognition Gate

This block sits beside the sequencer of a small 8-bit processor core and decides, once per instruction, whether the core enters an interrupt sequence at the next instruction boundary. The core supplies two timing strobes: `poll_cyc` in the second-to-last cycle of every instruction and `end_cyc` in the last cycle. The core also supplies its current interrupt-disable flag and two qualifiers. One marks an instruction that clears or restores that flag. The other marks a taken branch whose target stays on the same page. The block returns a registered take-NMI or take-IRQ decision, and that decision is valid in the final cycle of the instruction. The core pulses `vec_ack` when it starts fetching the NMI vector.

Both request lines are active low and pass through a two-stage synchroniser. The maskable request is a level, so it is sampled at the poll point only. The non-maskable request is an edge. An edge is caught in a pending latch, so a short pulse is still serviced. After service a new edge is accepted only once the line has been seen high for two consecutive cycles. An optional holding flop keeps the synchronised NMI line low after any low sample until software pulses `nmi_hold_clr`, which gives software control over re-arming.

Poll state machine: states `POLL_IDLE`, `POLL_NMI`, `POLL_IRQ`. A poll cycle selects `POLL_NMI` when an NMI is pending (transition *grant NMI*). Otherwise it selects `POLL_IRQ` when the IRQ qualifies (transition *grant IRQ*). Every other cycle returns to `POLL_IDLE` (transition *drop*). Re-arm state machine: `NMI_ARMED` moves to `NMI_WAIT_HI` on `vec_ack` (*serviced*). `NMI_WAIT_HI` moves to `NMI_HI_ONE` on the first high cycle (*first high*). `NMI_HI_ONE` moves to `NMI_ARMED` on a second high cycle (*rearm*) and falls back to `NMI_WAIT_HI` on a low cycle (*too soon*). Edges are detected only in `NMI_ARMED`.

Top module: `intr_recog`

## Requirements
- R1: After reset both take outputs are low, no NMI is pending, and the re-arm tracker is armed, so the first NMI falling edge after reset is accepted.
- R2: `take_irq` is high in the final cycle of an instruction when `irq_n` (active low, 0 = request) was low two cycles before the poll cycle, `irq_mask` is 0 during the poll cycle, no holdoff is active, and no NMI is granted. If `irq_n` falls one cycle later, that boundary is missed.
- R3: With `irq_mask` = 1 in the poll cycle, `take_irq` stays low at that boundary.
- R4: When `mask_restore` is high together with `end_cyc`, the poll of the next instruction ignores IRQ. The poll of the restoring instruction itself uses the `irq_mask` value present during that poll, which is the flag before the restore.
- R5: When `branch_near` is high in the poll cycle, IRQ is granted only if `irq_n` was low both two and three cycles before the poll cycle, so one extra cycle of assertion is needed.
- R6: A falling edge on `nmi_n` (1 to 0) sets a pending latch. The latch gives `take_nmi` at the next poll even if the line has been released by then. An edge seen one cycle before the poll cycle or earlier is granted at that poll.
- R7: If an NMI is pending at a poll, only `take_nmi` is raised, whatever `irq_mask` and the holdoff are. An IRQ line that stays low is granted at a later poll.
- R8: `vec_ack` clears the NMI pending latch, so the next poll gives no NMI.
- R9: After `vec_ack`, a new NMI edge is recognised only after the synchronised line has been high for two consecutive cycles. A line that is high for a single cycle and then low again produces no NMI.
- R10: With `nmi_hold_clr` low, a low NMI sample is held, so the line looks low and the block cannot re-arm until a `nmi_hold_clr` pulse. When `nmi_hold_clr` is high the holding flop is clear.
- R11: `take_nmi` and `take_irq` are never high together, and either one is high only in the cycle after a poll cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable request, active-low level |
| nmi_n | input | 1 | Non-maskable request, active-low edge |
| irq_mask | input | 1 | Current interrupt-disable flag, 1 = IRQ masked |
| poll_cyc | input | 1 | High in the second-to-last cycle of each instruction |
| end_cyc | input | 1 | High in the last cycle of each instruction |
| mask_restore | input | 1 | With end_cyc: instruction cleared or restored the disable flag |
| branch_near | input | 1 | With poll_cyc: taken branch to a same-page target |
| vec_ack | input | 1 | One-cycle pulse when the NMI vector fetch begins |
| nmi_hold_clr | input | 1 | Software clear strobe for the NMI holding flop |
| take_nmi | output | 1 | Enter the NMI sequence at this boundary |
| take_irq | output | 1 | Enter the IRQ sequence at this boundary |

## Verification
IRQ is asserted exactly at the sampling point and then one cycle too late, which pins down the two-cycle synchroniser plus the poll timing. The same arrival time is used with and without `branch_near`, and the outcomes differ only when the line lacks the extra cycle. Flag-clearing and flag-restoring sequences separate the holdoff from plain masking. NMI is tried as a short pulse, together with a pending IRQ, reasserted after one high cycle and after two, and with the holding flop left set and then cleared. This separates the edge latch, the priority, the re-arm rule and software release. A seeded random mix of instruction lengths, masks, restores, branches and line toggles is then compared cycle by cycle against a bench model built from the requirements.

// File: rtl/intr_recog_pkg.sv
package intr_recog_pkg;

    typedef enum logic [1:0] {
        POLL_IDLE = 2'd0,
        POLL_NMI  = 2'd1,
        POLL_IRQ  = 2'd2
    } poll_st_e;

    typedef enum logic [1:0] {
        NMI_ARMED   = 2'd0,
        NMI_WAIT_HI = 2'd1,
        NMI_HI_ONE  = 2'd2
    } rearm_st_e;

endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/intr_holdoff.sv
module intr_holdoff #(
    parameter int HOLD_INSNS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic end_cyc,
    input  logic restore,
    output logic busy
);
    localparam int CW = $clog2(HOLD_INSNS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (end_cyc) begin
            if (restore)          cnt <= CW'(HOLD_INSNS);
            else if (cnt != '0)   cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    // R4: a restoring instruction always opens a holdoff window
    p_holdoff_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cyc && restore) |=> busy);

    // R4: the window only shrinks at instruction ends
    p_holdoff_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !end_cyc) |=> busy);
endmodule

// File: rtl/intr_nmi_track.sv
module intr_nmi_track
    import intr_recog_pkg::*;
#(
    parameter bit USE_HOLD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_s,
    input  logic hold_clr,
    input  logic ack,
    output logic pend,
    output logic pend_d
);
    rearm_st_e st, st_nx;
    logic      eff_low;
    logic      prev_low;
    logic      hold_q;
    logic      fall;

    generate
        if (USE_HOLD) begin : g_hold
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hold_q <= 1'b0;
                else if (hold_clr) hold_q <= 1'b0;
                else if (!nmi_s)   hold_q <= 1'b1;
            end
            assign eff_low = !nmi_s || hold_q;
        end else begin : g_direct
            assign hold_q  = 1'b0;
            assign eff_low = !nmi_s;
        end
    endgenerate

    assign fall = (st == NMI_ARMED) && eff_low && !prev_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= NMI_ARMED;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (ack) begin
            st_nx = NMI_WAIT_HI;
        end else begin
            unique case (st)
                NMI_ARMED:   st_nx = NMI_ARMED;
                NMI_WAIT_HI: st_nx = eff_low ? NMI_WAIT_HI : NMI_HI_ONE;
                NMI_HI_ONE:  st_nx = eff_low ? NMI_WAIT_HI : NMI_ARMED;
                default:     st_nx = NMI_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_low <= 1'b0;
            pend     <= 1'b0;
            pend_d   <= 1'b0;
        end else begin
            prev_low <= eff_low;
            pend_d   <= ack ? 1'b0 : pend;
            if (ack)       pend <= 1'b0;
            else if (fall) pend <= 1'b1;
        end
    end

    // R8: acknowledge empties the latch
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !pend);

    // R9: the latch only fills while the tracker is armed
    p_edge_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(st == NMI_ARMED));

    // R9: re-arming needs two high cycles in a row
    p_rearm_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == NMI_ARMED && $past(st) != NMI_ARMED) |-> ($past(!eff_low) && $past(!eff_low, 2)));

    // R10: while held and not cleared the line stays low
    p_hold_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !hold_clr) |=> eff_low);
endmodule

// File: rtl/intr_recog.sv
module intr_recog
    import intr_recog_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int HOLD_INSNS   = 1,
    parameter bit USE_NMI_HOLD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic irq_mask,
    input  logic poll_cyc,
    input  logic end_cyc,
    input  logic mask_restore,
    input  logic branch_near,
    input  logic vec_ack,
    input  logic nmi_hold_clr,
    output logic take_nmi,
    output logic take_irq
);
    poll_st_e st, st_nx;
    logic     irq_s, irq_d, nmi_s;
    logic     pend, pend_d;
    logic     hold_busy;
    logic     nmi_use, irq_low, irq_go;

    intr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_irq_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_n), .q(irq_s)
    );

    intr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_nmi_sync (
        .clk(clk), .rst_n(rst_n), .d(nmi_n), .q(nmi_s)
    );

    intr_nmi_track #(.USE_HOLD(USE_NMI_HOLD)) i_nmi_track (
        .clk(clk), .rst_n(rst_n), .nmi_s(nmi_s), .hold_clr(nmi_hold_clr),
        .ack(vec_ack), .pend(pend), .pend_d(pend_d)
    );

    intr_holdoff #(.HOLD_INSNS(HOLD_INSNS)) i_holdoff (
        .clk(clk), .rst_n(rst_n), .end_cyc(end_cyc),
        .restore(mask_restore), .busy(hold_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_d <= 1'b1;
        else        irq_d <= irq_s;
    end

    assign nmi_use = branch_near ? pend_d : pend;
    assign irq_low = !irq_s && (!branch_near || !irq_d);
    assign irq_go  = irq_low && !irq_mask && !hold_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= POLL_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = POLL_IDLE;
        unique case (st)
            POLL_IDLE, POLL_NMI, POLL_IRQ: begin
                if (poll_cyc) begin
                    if (nmi_use)     st_nx = POLL_NMI;
                    else if (irq_go) st_nx = POLL_IRQ;
                end
            end
            default: st_nx = POLL_IDLE;
        endcase
    end

    always_comb begin
        take_nmi = 1'b0;
        take_irq = 1'b0;
        unique case (st)
            POLL_NMI: take_nmi = 1'b1;
            POLL_IRQ: take_irq = 1'b1;
            default: ;
        endcase
    end

    // R11: never both grants
    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_nmi, take_irq}));

    // R11: grants only follow a poll cycle
    p_after_poll_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi || take_irq) |-> $past(poll_cyc));

    // R3: mask blocks IRQ
    p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_cyc && irq_mask) |=> !take_irq);

    // R4: holdoff blocks IRQ
    p_holdoff_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_cyc && hold_busy) |=> !take_irq);

    // R5: a near branch needs the earlier sample low too
    p_branch_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_cyc && branch_near && irq_d) |=> !take_irq);

    // R7: a usable pending NMI always wins
    p_nmi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_cyc && nmi_use) |=> take_nmi);
endmodule

// File: tb/test_intr_recog.sv
`timescale 1ns/1ps
module test_intr_recog;
    localparam int HOLD = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_n = 1'b1, nmi_n = 1'b1, irq_mask = 1'b0;
    logic poll_cyc = 1'b0, end_cyc = 1'b0, mask_restore = 1'b0;
    logic branch_near = 1'b0, vec_ack = 1'b0, nmi_hold_clr = 1'b1;
    logic take_nmi, take_irq;

    intr_recog i_intr_recog (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
        .irq_mask(irq_mask), .poll_cyc(poll_cyc), .end_cyc(end_cyc),
        .mask_restore(mask_restore), .branch_near(branch_near),
        .vec_ack(vec_ack), .nmi_hold_clr(nmi_hold_clr),
        .take_nmi(take_nmi), .take_irq(take_irq)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic irq_lv = 1'b1, nmi_lv = 1'b1, mask_lv = 1'b0, clr_lv = 1'b1;
    logic got_n, got_i, ack_due = 1'b0;

    // bench model state
    logic m_is1 = 1, m_is2 = 1, m_id = 1, m_ns1 = 1, m_ns2 = 1;
    logic m_hold = 0, m_prev = 0, m_pend = 0, m_pend_d = 0, m_tn = 0, m_ti = 0;
    int   m_arm = 0, m_cnt = 0;

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input logic p, input logic l, input logic r,
                        input logic b, input logic a);
        logic effl, edg, iok, nok, n_tn, n_ti, n_pend, n_hold;
        int   n_arm, n_cnt;
        @(negedge clk);
        check("R11 model nmi", take_nmi, m_tn);
        check("R11 model irq", take_irq, m_ti);
        if (l) begin
            got_n = take_nmi;
            got_i = take_irq;
        end
        irq_n = irq_lv; nmi_n = nmi_lv; irq_mask = mask_lv; nmi_hold_clr = clr_lv;
        poll_cyc = p; end_cyc = l; mask_restore = r; branch_near = b; vec_ack = a;
        effl = !m_ns2 || m_hold;
        edg  = (m_arm == 0) && effl && !m_prev;
        iok  = b ? (!m_is2 && !m_id) : !m_is2;
        nok  = b ? m_pend_d : m_pend;
        n_tn = p && nok;
        n_ti = p && !nok && iok && !mask_lv && (m_cnt == 0);
        if (a) n_arm = 1;
        else if (m_arm == 0) n_arm = 0;
        else if (effl) n_arm = 1;
        else n_arm = (m_arm == 1) ? 2 : 0;
        n_pend = a ? 1'b0 : (edg ? 1'b1 : m_pend);
        n_hold = clr_lv ? 1'b0 : (!m_ns2 ? 1'b1 : m_hold);
        n_cnt  = m_cnt;
        if (l) n_cnt = r ? HOLD : ((m_cnt > 0) ? m_cnt - 1 : 0);
        m_pend_d = a ? 1'b0 : m_pend;
        m_pend = n_pend; m_arm = n_arm; m_hold = n_hold; m_prev = effl;
        m_id = m_is2; m_is2 = m_is1; m_is1 = irq_lv;
        m_ns2 = m_ns1; m_ns1 = nmi_lv;
        m_cnt = n_cnt; m_tn = n_tn; m_ti = n_ti;
    endtask

    task automatic instr(input int n, input logic msk, input logic rf, input logic br,
                         input int is, input int ic, input int ns, input int nc);
        for (int k = 0; k < n; k++) begin
            if (k == is) irq_lv = 1'b0;
            if (k == ic) irq_lv = 1'b1;
            if (k == ns) nmi_lv = 1'b0;
            if (k == nc) nmi_lv = 1'b1;
            mask_lv = msk;
            step(k == n-2, k == n-1, rf && (k == n-1), br && (k == n-2), ack_due && (k == 0));
        end
        ack_due = got_n;
    endtask

    task automatic expect2(input string req, input logic en, input logic ei);
        check({req, " take_nmi"}, got_n, en);
        check({req, " take_irq"}, got_i, ei);
    endtask

    task automatic plain(input int n);
        instr(n, 1'b0, 1'b0, 1'b0, -1, -1, -1, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset take_nmi", take_nmi, 1'b0);
        check("R1 reset take_irq", take_irq, 1'b0);
        plain(4);
        // R2
        instr(4, 0, 0, 0, 0, -1, -1, -1);  expect2("R2 on time", 0, 1);
        instr(4, 0, 0, 0, -1, 0, -1, -1);  expect2("R2 released", 0, 0);
        instr(4, 0, 0, 0, 1, -1, -1, -1);  expect2("R2 one cycle late", 0, 0);
        plain(4);                          expect2("R2 next boundary", 0, 1);
        // R3
        instr(4, 1, 0, 0, -1, -1, -1, -1); expect2("R3 masked", 0, 0);
        // R4
        instr(2, 1, 1, 0, -1, -1, -1, -1); expect2("R4 clear-flag insn", 0, 0);
        plain(4);                          expect2("R4 holdoff", 0, 0);
        plain(4);                          expect2("R4 after holdoff", 0, 1);
        instr(4, 0, 1, 0, -1, -1, -1, -1); expect2("R4 restore uses old flag", 0, 1);
        instr(4, 0, 0, 0, -1, 0, -1, -1);  expect2("R4 holdoff after restore", 0, 0);
        // R5
        instr(2, 0, 0, 0, 1, -1, -1, -1);  expect2("R5 setup", 0, 0);
        instr(3, 0, 0, 1, -1, -1, -1, -1); expect2("R5 near branch short", 0, 0);
        instr(4, 0, 0, 0, -1, 0, -1, -1);  expect2("R5 release", 0, 0);
        instr(2, 0, 0, 0, 1, -1, -1, -1);  expect2("R5 setup again", 0, 0);
        instr(3, 0, 0, 0, -1, -1, -1, -1); expect2("R5 no branch same timing", 0, 1);
        instr(3, 0, 0, 1, -1, -1, -1, -1); expect2("R5 near branch long", 0, 1);
        instr(4, 0, 0, 0, -1, 0, -1, -1);  expect2("R5 release", 0, 0);
        // R6, R1 first edge after reset
        instr(4, 0, 0, 0, -1, -1, 0, 2);   expect2("R6 pulse late", 0, 0);
        plain(4);                          expect2("R6 R1 latched pulse", 1, 0);
        plain(4);                          expect2("R8 after ack", 0, 0);
        // R7
        instr(4, 0, 0, 0, -1, -1, 0, -1);  expect2("R7 nmi edge", 0, 0);
        instr(4, 0, 0, 0, 0, -1, -1, -1);  expect2("R7 priority", 1, 0);
        plain(4);                          expect2("R7 irq follows", 0, 1);
        instr(4, 0, 0, 0, -1, 0, -1, -1);  expect2("R7 release irq", 0, 0);
        // R9
        instr(4, 0, 0, 0, -1, -1, 2, 1);   expect2("R9 one high cycle", 0, 0);
        plain(4);                          expect2("R9 too soon", 0, 0);
        instr(4, 0, 0, 0, -1, -1, 3, 0);   expect2("R9 long release", 0, 0);
        plain(4);                          expect2("R9 rearmed", 1, 0);
        plain(4);                          expect2("R8 ack again", 0, 0);
        // R10
        clr_lv = 1'b0;
        instr(4, 0, 0, 0, -1, -1, -1, 0);  expect2("R10 held", 0, 0);
        instr(4, 0, 0, 0, -1, -1, 0, 1);   expect2("R10 held pulse", 0, 0);
        plain(4);                          expect2("R10 no rearm", 0, 0);
        clr_lv = 1'b1;
        plain(4);                          expect2("R10 sw clear", 0, 0);
        clr_lv = 1'b0;
        instr(4, 0, 0, 0, -1, -1, 0, 1);   expect2("R10 edge", 0, 0);
        plain(4);                          expect2("R10 latched", 1, 0);
        plain(4);                          expect2("R10 acked", 0, 0);
        instr(4, 0, 0, 0, -1, -1, 0, 1);   expect2("R10 no sw clear", 0, 0);
        plain(4);                          expect2("R10 still held", 0, 0);
        clr_lv = 1'b1;
        // random mix checked against the model every cycle (R2..R11)
        for (int t = 0; t < 400; t++) begin
            int n;
            logic brr;
            n   = 2 + int'($urandom_range(5));
            brr = (n == 3) && ($urandom_range(9) < 3);
            for (int k = 0; k < n; k++) begin
                if ($urandom_range(9) < 2) irq_lv = ~irq_lv;
                if ($urandom_range(9) < 1) nmi_lv = ~nmi_lv;
                clr_lv = ($urandom_range(1) == 0);
                if (k == 0) mask_lv = ($urandom_range(1) == 0);
                step(k == n-2, k == n-1, (k == n-1) && ($urandom_range(9) == 0),
                     brr && (k == n-2), ack_due && (k == 0));
            end
            ack_due = got_n;
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule